// File: doc/BRIEF.md
# Cache Control and Tag Invalidation Sequencer

This block holds a 32-bit cache control register and carries out the tag-array maintenance that the register commands. Software writes the register through a single-cycle write port and reads it back on a read port. Writing the invalidate command starts a sweep that clears one tag valid bit per clock. It covers the whole array, one half, or nothing, depending on the disable and select bits written in the same word. A busy flag covers the sweep, from a fixed overhead phase to the last cleared entry.

The valid bits of the tag array live inside the block. A cache-push command can clear a single entry, selected by address bits [10:4], unless the push-invalidation disable bit is set. A line-fill engine outside the block asks to write a completed fill into an entry and gets its answer in the same cycle. While freeze is set, a fill may only land in an entry that is currently invalid. A lookup port reports the valid bit of any entry.

Top module: `cache_ctl_seq`

## Requirements
- R1: After reset the register reads 0, busy is low and every entry reads invalid on the lookup port.
- R2: Bits 31, 28, 27 and 23:0 are stored as written and read back. Bits 30:29, 26:25 and the invalidate command bit 24 always read 0.
- R3: A write with bit 24 set and a non-empty scope raises busy in the following cycle. Busy stays high for 3 overhead cycles plus one cycle per entry in scope (131 for the full array of 128, 67 for a half), and then every entry in scope is invalid.
- R4: Scope is decoded from the written word, using bit 23 (instruction disable), bit 22 (data disable), bit 21 (instruction-half select) and bit 20 (data-half select). With both disable bits set, the whole array is swept. Otherwise bit 21 adds entries 0–63 and bit 20 adds entries 64–127. With neither select set, nothing happens and busy stays low.
- R5: The sweep runs the same way whether bit 31 (cache enable) is 0 or 1.
- R6: A push request clears the entry indexed by push_addr[10:4] when bit 28 is 0. It changes nothing when bit 28 is 1.
- R7: While busy is high, push requests and new invalidate commands are ignored, and the running sweep keeps its length.
- R8: fill_accept answers in the same cycle as fill_req. It is 0 when bit 31 is 0. An accepted fill makes its entry valid from the next cycle.
- R9: With bit 27 (freeze) set, a fill aimed at a valid entry is rejected, and a fill aimed at an invalid entry is accepted.
- R10: Entries outside the sweep scope keep their valid state through the sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| push_req | input | 1 | Single-entry push invalidate request |
| push_addr | input | 32 | Push address; bits [10:4] pick the entry |
| fill_req | input | 1 | Request to write a completed fill |
| fill_idx | input | 7 | Entry targeted by the fill |
| fill_accept | output | 1 | Same-cycle fill acceptance |
| lk_idx | input | 7 | Lookup entry index |
| lk_valid | output | 1 | Valid bit of the looked-up entry |
| busy | output | 1 | Invalidate sequence in progress |

## Verification
The sweep is tried first on a fully valid array with every scope encoding: both selects, each select alone, no select, and both disable bits with no select. Each run is timed by busy length and then probed at every entry, which tells a full sweep from a half sweep, the lower half from the upper half, and a missing sweep from a wrong one. The both-disables case is run with the enable bit cleared, which shows that the sweep does not depend on enable. Push and invalidate requests issued during a sweep on the other half, and push with the disable bit set, show whether the block ignores them. Fills into valid and invalid entries, with freeze on and off and with enable off, tell the freeze rule apart from the enable gate.

// File: rtl/cache_ctl_pkg.sv
// Package: shared control-register bit positions, masks and sequencer states.
// Assumes a 32-bit control register.
package cache_ctl_pkg;
    localparam int BIT_ENABLE   = 31;
    localparam int BIT_NOPUSH   = 28;
    localparam int BIT_FREEZE   = 27;
    localparam int BIT_INVCMD   = 24;
    localparam int BIT_IDIS     = 23;
    localparam int BIT_DDIS     = 22;
    localparam int BIT_SEL_I    = 21;
    localparam int BIT_SEL_D    = 20;
    // Stored bits: 31, 28, 27 and 23:0
    localparam logic [31:0] STORE_MASK = 32'h98FF_FFFF;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_WAIT  = 2'd1,
        SEQ_SWEEP = 2'd2
    } seq_state_t;
endpackage

// File: rtl/cache_ctl_reg.sv
// Module: control register storage and invalidate-scope decode.
// Assumes a single-cycle write; the invalidate bit is a command and is never stored.
module cache_ctl_reg
    import cache_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        inv_cmd,
    output logic        inv_lo,
    output logic        inv_hi,
    output logic        cfg_enable,
    output logic        cfg_nopush,
    output logic        cfg_freeze
);
    logic [31:0] ctl_q;
    logic        both_dis;

    // Store writable bits; reserved bits and the command bit stay zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_en)
            ctl_q <= wr_data & STORE_MASK;
    end

    // Decode the command and its scope from the word being written
    always_comb begin
        both_dis = wr_data[BIT_IDIS] & wr_data[BIT_DDIS];
        inv_cmd  = wr_en & wr_data[BIT_INVCMD];
        inv_lo   = both_dis | wr_data[BIT_SEL_I];
        inv_hi   = both_dis | wr_data[BIT_SEL_D];
    end

    assign rd_data    = ctl_q;
    assign cfg_enable = ctl_q[BIT_ENABLE];
    assign cfg_nopush = ctl_q[BIT_NOPUSH];
    assign cfg_freeze = ctl_q[BIT_FREEZE];
endmodule

// File: rtl/cache_inv_seq.sv
// Module: invalidate sweep sequencer. Waits OVERHEAD cycles, then emits one
// clear index per cycle across the selected half or halves.
// Assumes NUM_ENTRIES is even and OVERHEAD >= 1.
module cache_inv_seq
    import cache_ctl_pkg::*;
#(
    parameter int NUM_ENTRIES = 128,
    parameter int OVERHEAD    = 3,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int OVH_W      = $clog2(OVERHEAD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_cmd,
    input  logic             inv_lo,
    input  logic             inv_hi,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx,
    output logic             busy
);
    localparam logic [IDX_W-1:0] HALF_IDX = IDX_W'(NUM_ENTRIES / 2);
    localparam logic [IDX_W-1:0] LAST_LO  = IDX_W'(NUM_ENTRIES / 2 - 1);
    localparam logic [IDX_W-1:0] LAST_HI  = IDX_W'(NUM_ENTRIES - 1);
    localparam logic [OVH_W-1:0] OVH_END  = OVH_W'(OVERHEAD - 1);

    seq_state_t       state_q;
    logic [OVH_W-1:0] ovh_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;

    // Step the sequencer: accept a command only when idle and scope non-empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            ovh_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (inv_cmd && (inv_lo || inv_hi)) begin
                        state_q <= SEQ_WAIT;
                        ovh_q   <= '0;
                        idx_q   <= inv_lo ? '0 : HALF_IDX;
                        last_q  <= inv_hi ? LAST_HI : LAST_LO;
                    end
                end
                SEQ_WAIT: begin
                    if (ovh_q == OVH_END)
                        state_q <= SEQ_SWEEP;
                    else
                        ovh_q <= ovh_q + 1'b1;
                end
                SEQ_SWEEP: begin
                    if (idx_q == last_q)
                        state_q <= SEQ_IDLE;
                    else
                        idx_q <= idx_q + 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign clr_en  = (state_q == SEQ_SWEEP);
    assign clr_idx = idx_q;
    assign busy    = (state_q != SEQ_IDLE);
endmodule

// File: rtl/cache_tag_valid.sv
// Module: tag valid-bit array with sweep clear, push clear and fill set.
// Assumes clears win over a fill to the same entry in the same cycle.
module cache_tag_valid #(
    parameter int NUM_ENTRIES = 128,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_en,
    input  logic [IDX_W-1:0]       clr_idx,
    input  logic                   push_clr,
    input  logic [IDX_W-1:0]       push_idx,
    input  logic                   fill_req,
    input  logic [IDX_W-1:0]       fill_idx,
    input  logic                   cfg_enable,
    input  logic                   cfg_freeze,
    output logic                   fill_accept,
    input  logic [IDX_W-1:0]       lk_idx,
    output logic                   lk_valid,
    output logic [NUM_ENTRIES-1:0] valid_vec
);
    logic [NUM_ENTRIES-1:0] valid_q;

    // Fill gate: cache must be enabled, and freeze protects valid entries
    assign fill_accept = fill_req && cfg_enable && !(cfg_freeze && valid_q[fill_idx]);

    // Update valid bits; later statements take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_accept) valid_q[fill_idx] <= 1'b1;
            if (push_clr)    valid_q[push_idx] <= 1'b0;
            if (clr_en)      valid_q[clr_idx]  <= 1'b0;
        end
    end

    assign lk_valid  = valid_q[lk_idx];
    assign valid_vec = valid_q;
endmodule

// File: rtl/cache_ctl_seq.sv
// Module: top of the cache control block. Joins the control register, the
// invalidate sequencer and the tag valid array; gates push requests.
// Assumes 16-byte lines (LINE_OFS = 4) for push indexing.
module cache_ctl_seq #(
    parameter int NUM_ENTRIES = 128,
    parameter int OVERHEAD    = 3,
    parameter int LINE_OFS    = 4,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             push_req,
    input  logic [31:0]      push_addr,
    input  logic             fill_req,
    input  logic [IDX_W-1:0] fill_idx,
    output logic             fill_accept,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_valid,
    output logic             busy
);
    logic                   inv_cmd, inv_lo, inv_hi;
    logic                   cfg_enable, cfg_nopush, cfg_freeze;
    logic                   clr_en;
    logic [IDX_W-1:0]       clr_idx;
    logic                   push_clr;
    logic [IDX_W-1:0]       push_idx;
    logic [NUM_ENTRIES-1:0] valid_vec;

    cache_ctl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .inv_cmd(inv_cmd), .inv_lo(inv_lo), .inv_hi(inv_hi),
        .cfg_enable(cfg_enable), .cfg_nopush(cfg_nopush), .cfg_freeze(cfg_freeze)
    );

    cache_inv_seq #(.NUM_ENTRIES(NUM_ENTRIES), .OVERHEAD(OVERHEAD)) u_seq (
        .clk(clk), .rst_n(rst_n), .inv_cmd(inv_cmd), .inv_lo(inv_lo),
        .inv_hi(inv_hi), .clr_en(clr_en), .clr_idx(clr_idx), .busy(busy)
    );

    // Push clears one entry unless disabled or a sweep is running
    assign push_idx = push_addr[LINE_OFS +: IDX_W];
    assign push_clr = push_req && !busy && !cfg_nopush;

    cache_tag_valid #(.NUM_ENTRIES(NUM_ENTRIES)) u_tags (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_idx(clr_idx),
        .push_clr(push_clr), .push_idx(push_idx), .fill_req(fill_req),
        .fill_idx(fill_idx), .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
        .fill_accept(fill_accept), .lk_idx(lk_idx), .lk_valid(lk_valid),
        .valid_vec(valid_vec)
    );
endmodule

// File: rtl/cache_ctl_chk.sv
// Module: assertion checker bound to cache_ctl_seq.
module cache_ctl_chk #(
    parameter int NUM_ENTRIES = 128,
    parameter int OVERHEAD    = 3,
    localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [31:0]            wr_data,
    input logic [31:0]            rd_data,
    input logic                   push_clr,
    input logic [IDX_W-1:0]       push_idx,
    input logic                   fill_accept,
    input logic [IDX_W-1:0]       fill_idx,
    input logic                   cfg_freeze,
    input logic                   cfg_enable,
    input logic                   clr_en,
    input logic                   busy,
    input logic [NUM_ENTRIES-1:0] valid_vec
);
    logic [15:0] busy_len;

    // Count consecutive busy cycles for the length bound
    always_ff @(posedge clk) begin
        if (!rst_n)     busy_len <= '0;
        else if (busy)  busy_len <= busy_len + 1'b1;
        else            busy_len <= '0;
    end

    assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en && wr_data[24]));

    assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= 16'(OVERHEAD + NUM_ENTRIES));

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == ($past(wr_data) & 32'h98FF_FFFF)));

    assert_push_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_clr |=> !valid_vec[$past(push_idx)]);

    assert_push_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_clr |-> !busy);

    assert_fill_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_accept && !push_clr && !clr_en) |=> valid_vec[$past(fill_idx)]);

    assert_fill_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_accept |-> cfg_enable);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_accept && cfg_freeze) |-> !valid_vec[fill_idx]);
endmodule

bind cache_ctl_seq cache_ctl_chk #(.NUM_ENTRIES(NUM_ENTRIES), .OVERHEAD(OVERHEAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .push_clr(push_clr), .push_idx(push_idx), .fill_accept(fill_accept),
    .fill_idx(fill_idx), .cfg_freeze(cfg_freeze), .cfg_enable(cfg_enable),
    .clr_en(clr_en), .busy(busy), .valid_vec(valid_vec)
);

// File: tb/tb_cache_ctl_seq.sv
module tb_cache_ctl_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        push_req = 1'b0;
    logic [31:0] push_addr = '0;
    logic        fill_req = 1'b0;
    logic [6:0]  fill_idx = '0;
    logic        fill_accept;
    logic [6:0]  lk_idx = '0;
    logic        lk_valid;
    logic        busy;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] NOP = 32'h1000_0000;
    localparam logic [31:0] FRZ = 32'h0800_0000;
    localparam logic [31:0] INV = 32'h0100_0000;
    localparam logic [31:0] IDS = 32'h0080_0000;
    localparam logic [31:0] DDS = 32'h0040_0000;
    localparam logic [31:0] SLI = 32'h0020_0000;
    localparam logic [31:0] SLD = 32'h0010_0000;

    always #5 clk = ~clk;

    cache_ctl_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .push_req(push_req), .push_addr(push_addr),
        .fill_req(fill_req), .fill_idx(fill_idx), .fill_accept(fill_accept),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic reg_wr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    // Write an invalidate word and return the busy length in cycles
    task automatic inv_run(input logic [31:0] v, output int len);
        len = 0;
        reg_wr(v);
        while (busy && len < 1000) begin len++; @(negedge clk); end
    endtask

    task automatic do_fill(input int idx, output bit acc);
        @(negedge clk); fill_req = 1'b1; fill_idx = 7'(idx);
        #1 acc = fill_accept;
        @(negedge clk); fill_req = 1'b0;
    endtask

    task automatic fill_all();
        bit a;
        reg_wr(EN);
        for (int i = 0; i < 128; i++) do_fill(i, a);
    endtask

    // Count valid entries in [lo, hi]
    task automatic count_valid(input int lo, input int hi, output int cnt);
        cnt = 0;
        for (int i = lo; i <= hi; i++) begin lk_idx = 7'(i); #1; if (lk_valid) cnt++; end
    endtask

    task automatic t_reset();
        int c;
        chk(rd_data == 0, "R1 reg", rd_data, 0);
        chk(busy == 0, "R1 busy", busy, 0);
        count_valid(0, 127, c);
        chk(c == 0, "R1 valid", c, 0);
    endtask

    task automatic t_register();
        reg_wr(32'hFEFF_FFFF);
        chk(rd_data == 32'h98FF_FFFF, "R2 readback", rd_data, 32'h98FF_FFFF);
        reg_wr(32'h0000_0000);
        chk(rd_data == 0, "R2 clear", rd_data, 0);
    endtask

    task automatic t_full();
        int len, c;
        fill_all();
        inv_run(EN | INV | SLI | SLD, len);
        chk(len == 131, "R3 full busy length", len, 131);
        count_valid(0, 127, c);
        chk(c == 0, "R3 full cleared", c, 0);
    endtask

    task automatic t_half_i();
        int len, c;
        fill_all();
        inv_run(EN | INV | SLI, len);
        chk(len == 67, "R3 half busy length", len, 67);
        count_valid(0, 63, c);
        chk(c == 0, "R4 instr half cleared", c, 0);
        count_valid(64, 127, c);
        chk(c == 64, "R10 data half kept", c, 64);
    endtask

    task automatic t_half_d();
        int len, c;
        fill_all();
        inv_run(EN | INV | SLD | IDS, len);
        chk(len == 67, "R4 data half length", len, 67);
        count_valid(64, 127, c);
        chk(c == 0, "R4 data half cleared", c, 0);
        count_valid(0, 63, c);
        chk(c == 64, "R10 instr half kept", c, 64);
    endtask

    task automatic t_none();
        int len, c;
        fill_all();
        inv_run(EN | INV, len);
        chk(len == 0, "R4 empty scope busy", len, 0);
        count_valid(0, 127, c);
        chk(c == 128, "R4 empty scope keeps", c, 128);
    endtask

    task automatic t_disabled();
        int len, c;
        fill_all();
        inv_run(INV | IDS | DDS, len);
        chk(len == 131, "R5 sweep with enable off", len, 131);
        count_valid(0, 127, c);
        chk(c == 0, "R4 both disables full", c, 0);
    endtask

    task automatic t_push();
        int c;
        fill_all();
        @(negedge clk); push_req = 1'b1; push_addr = 32'h0000_0050;
        @(negedge clk); push_req = 1'b0;
        lk_idx = 7'd5; #1;
        chk(lk_valid == 0, "R6 push clears", lk_valid, 0);
        count_valid(0, 127, c);
        chk(c == 127, "R6 push single entry", c, 127);
        reg_wr(EN | NOP);
        @(negedge clk); push_req = 1'b1; push_addr = 32'h0000_0FF0;
        @(negedge clk); push_req = 1'b0;
        lk_idx = 7'd127; #1;
        chk(lk_valid == 1, "R6 push disabled", lk_valid, 1);
    endtask

    task automatic t_busy_ignore();
        int len, c;
        fill_all();
        len = 0;
        reg_wr(EN | INV | SLI);
        @(negedge clk); push_req = 1'b1; push_addr = 32'h0000_0640; len++;
        @(negedge clk); push_req = 1'b0; len++;
        @(negedge clk); wr_en = 1'b1; wr_data = EN | INV | SLD; len++;
        @(negedge clk); wr_en = 1'b0; wr_data = '0; len++;
        while (busy && len < 1000) begin len++; @(negedge clk); end
        chk(len == 67, "R7 sweep length unchanged", len, 67);
        count_valid(64, 127, c);
        chk(c == 64, "R7 push and command ignored", c, 64);
    endtask

    task automatic t_fill();
        bit a; int len;
        inv_run(INV | SLI | SLD, len);
        reg_wr(32'h0);
        do_fill(9, a);
        chk(a == 0, "R8 reject when disabled", a, 0);
        lk_idx = 7'd9; #1;
        chk(lk_valid == 0, "R8 no set when rejected", lk_valid, 0);
        reg_wr(EN | FRZ);
        do_fill(9, a);
        chk(a == 1, "R9 freeze invalid target", a, 1);
        lk_idx = 7'd9; #1;
        chk(lk_valid == 1, "R8 accepted sets valid", lk_valid, 1);
        do_fill(9, a);
        chk(a == 0, "R9 freeze valid target", a, 0);
        reg_wr(EN);
        do_fill(9, a);
        chk(a == 1, "R8 no freeze valid target", a, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_register();
        t_full();
        t_half_i();
        t_half_d();
        t_none();
        t_disabled();
        t_push();
        t_busy_ignore();
        t_fill();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule